// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Unit

This unit holds the volatile status register of a serial-interface nonvolatile byte memory. It decides, one byte at a time, whether the memory array may be written. The serial engine upstream decodes commands and sends single-cycle strobes for set-enable, clear-enable and status-write. It also sends a strobe for each memory byte write, with its address, and a strobe when chip select returns high. The unit returns the status byte for the read-status command and a write grant for every byte request.

Protection has two layers. A write-enable latch must be set before any memory or status write can take effect. The two block-protect bits name a range: nothing, the upper quarter, the upper half, or the whole array. A byte request inside that range is always refused. A status-write-disable bit locks the status register, but only while the write-protect pin is driven low. That pin passes through a two-flop synchronizer.

Strobes carry no handshake. Every strobe is accepted in the cycle it is presented, and the grant is a combinational answer in that same cycle. The unit never applies back-pressure, so the engine needs no ready signal.

Top module: `wps_unit`

## Requirements
- R1: Reset (rst_n low) clears the whole status byte to 0x00.
- R2: The status byte reads bit7 = status-write-disable, bits 3:2 = block-protect, bit1 = write-enable latch. Bits 6:4 and bit0 always read 0.
- R3: A set-enable strobe sets the latch on the next clock. A clear-enable strobe clears it. Clear wins if both arrive in the same cycle.
- R4: wr_grant is 1 only while the latch is set and the addressed byte lies outside the protected range.
- R5: A status-write strobe while the latch is clear changes nothing.
- R6: An accepted status write loads bit7 and bits 3:2 from wrsr_data. Data bits 6:4 and 1:0 are ignored and do not touch the latch.
- R7: Block-protect 00 protects nothing. 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF, and 11 protects 0x000–0xFFF.
- R8: When bit7 = 1 and the synchronized write-protect pin is 0, a status write is ignored. The other three combinations allow it once the latch is set.
- R9: The write-protect pin is seen through two flops. A status write in the same cycle the pin falls still uses the old (high) level.
- R10: A chip-select-rise strobe clears the latch if a byte request or status write arrived while the latch was set during that select, including in the same cycle. Otherwise it leaves the latch alone.
- R11: In the cycle of a latch clear or a block-protect change, wr_grant is still judged on the register values from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_wrsr | input | 1 | Status-write strobe, data byte complete |
| wrsr_data | input | 8 | Status-write data byte |
| wr_req | input | 1 | Memory byte write request |
| wr_addr | input | 12 | Byte address of the request |
| cs_rise | input | 1 | Chip-select deassertion strobe |
| wp_n | input | 1 | Asynchronous write-protect pin, active low |
| status_byte | output | 8 | Status byte for the read-status command |
| wr_grant | output | 1 | Grant for the current byte request |

## Verification
Two collisions get their own checks. The first is a byte request in the same cycle as the chip-select rise that ends its own command. The second is a byte request in the same cycle as a status write that widens the protected range. In both cases the bench drives the two strobes on one falling edge. It reads the grant before the next rising edge and expects it to follow the old register values. After that edge it reads the status byte and expects the latch cleared or the range updated. A similar collision pairs a falling write-protect pin with a status write, and the bench expects the write to land.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
    logic       wel;
  } wps_state_t;

  localparam logic [1:0] BP_OPEN    = 2'b00;
  localparam logic [1:0] BP_QUARTER = 2'b01;
  localparam logic [1:0] BP_HALF    = 2'b10;
  localparam logic [1:0] BP_ALL     = 2'b11;

  function automatic logic [7:0] pack_status(input wps_state_t s);
    return {s.srwd, 3'b000, s.bp, s.wel, 1'b0};
  endfunction
endpackage

// File: rtl/wps_sync.sv
module wps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wps_region.sv
module wps_region
  import wps_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int TOP = AW - 1;

  logic in_upper_half, in_upper_quarter;

  assign in_upper_half    = addr[TOP];
  assign in_upper_quarter = addr[TOP] & addr[TOP-1];

  always_comb begin
    unique case (bp)
      BP_OPEN:    hit = 1'b0;
      BP_QUARTER: hit = in_upper_quarter;
      BP_HALF:    hit = in_upper_half;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wps_status.sv
module wps_status
  import wps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic       clr_en,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       arm,
  input  logic       cs_rise,
  output wps_state_t st
);
  logic armed;
  logic unused_din;

  assign unused_din = &{1'b0, din[6:4], din[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      armed <= 1'b0;
    end else begin
      if (load) begin
        st.srwd <= din[7];
        st.bp   <= din[3:2];
      end
      if (clr_en)                        st.wel <= 1'b0;
      else if (set_en)                   st.wel <= 1'b1;
      else if (cs_rise && (armed || arm)) st.wel <= 1'b0;
      armed <= cs_rise ? 1'b0 : (armed | arm);
    end
  end
endmodule

// File: rtl/wps_unit.sv
module wps_unit
  import wps_pkg::*;
#(
  parameter int AW        = 12,
  parameter int WP_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic          cs_rise,
  input  logic          wp_n,
  output logic [7:0]    status_byte,
  output logic          wr_grant
);
  wps_state_t st;
  logic wp_n_s, hw_lock, wrsr_take, arm_now, in_range;

  wps_sync #(.STAGES(WP_STAGES), .RST_VAL(1'b1)) u_wp_sync (
    .clk(clk), .rst_n(rst_n), .d(wp_n), .q(wp_n_s)
  );

  wps_region #(.AW(AW)) u_region (
    .bp(st.bp), .addr(wr_addr), .hit(in_range)
  );

  assign hw_lock   = st.srwd & ~wp_n_s;
  assign wrsr_take = cmd_wrsr & st.wel & ~hw_lock;
  assign arm_now   = (cmd_wrsr | wr_req) & st.wel;

  wps_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_en(cmd_wren), .clr_en(cmd_wrdi),
    .load(wrsr_take), .din(wrsr_data),
    .arm(arm_now), .cs_rise(cs_rise),
    .st(st)
  );

  assign status_byte = pack_status(st);
  assign wr_grant    = wr_req & st.wel & ~in_range;
endmodule

// File: rtl/wps_unit_chk.sv
module wps_unit_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wren,
  input logic          cmd_wrdi,
  input logic          cmd_wrsr,
  input logic [7:0]    wrsr_data,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic          cs_rise,
  input logic          wp_n,
  input logic [7:0]    status_byte,
  input logic          wr_grant
);
  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> status_byte == 8'h00);

  a_r3_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wren && !cmd_wrdi |=> status_byte[1]);

  a_r3_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi |=> !status_byte[1]);

  a_r4_grant_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> wr_req && status_byte[1]);

  a_r5_no_latch_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrsr && !status_byte[1] |=> $stable(status_byte[7:2]));

  a_r7_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[3:2] == 2'b11 |-> !wr_grant);

  a_r7_quarter_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant && status_byte[3:2] != 2'b00 |-> wr_addr[AW-1:AW-2] != 2'b11);

  a_r8_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrsr && status_byte[7] && !$past(wp_n, 2) && !$past(wp_n) |=> $stable(status_byte[7:2]));

  a_r6_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrsr && status_byte[1] && !status_byte[7] |=> status_byte[7] == $past(wrsr_data[7])
      && status_byte[3:2] == $past(wrsr_data[3:2]));
endmodule

bind wps_unit wps_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .wr_req(wr_req),
  .wr_addr(wr_addr), .cs_rise(cs_rise), .wp_n(wp_n),
  .status_byte(status_byte), .wr_grant(wr_grant)
);

// File: tb/sim_wps_unit.sv
`timescale 1ns/1ps
module sim_wps_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, wr_req = 0, cs_rise = 0, wp_n = 1;
  logic [7:0]  wrsr_data = 0;
  logic [11:0] wr_addr = 0;
  logic [7:0]  status_byte;
  logic        wr_grant;

  always #2.5 clk = ~clk;

  wps_unit u0 (.*);

  typedef struct { bit is_grant; logic [7:0] exp; string req; } item_t;
  item_t sbq[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(chk_ev) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sbq.pop_front();
      act = it.is_grant ? {7'b0, wr_grant} : status_byte;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s actual=%h expected=%h", it.req,
                 it.is_grant ? "grant" : "status", act, it.exp);
      end
    end
  end

  task automatic push(input bit g, input logic [7:0] e, input string r);
    item_t it;
    it.is_grant = g; it.exp = e; it.req = r;
    sbq.push_back(it);
    -> chk_ev;
    #0.2;
  endtask

  task automatic chk_st(input logic [7:0] e, input string r);
    push(1'b0, e, r);
  endtask

  task automatic cyc(input bit wen, input bit wdi, input bit wsr, input logic [7:0] d,
                     input bit rq, input logic [11:0] a, input bit csr,
                     input int gexp, input string r);
    @(negedge clk);
    cmd_wren = wen; cmd_wrdi = wdi; cmd_wrsr = wsr; wrsr_data = d;
    wr_req = rq; wr_addr = a; cs_rise = csr;
    #1;
    if (gexp >= 0) push(1'b1, gexp[7:0], r);
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wr_req = 0; cs_rise = 0;
  endtask

  task automatic wren();            cyc(1,0,0,8'h00,0,12'h0,0,-1,""); endtask
  task automatic wrsr(input logic [7:0] d); cyc(0,0,1,d,0,12'h0,0,-1,""); endtask
  task automatic csup();            cyc(0,0,0,8'h00,0,12'h0,1,-1,""); endtask
  task automatic wreq(input logic [11:0] a, input int g, input string r);
    cyc(0,0,0,8'h00,1,a,0,g,r);
  endtask
  task automatic settle_wp(input logic v);
    @(negedge clk); wp_n = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit prot(input int b, input logic [11:0] a);
    return (b == 3) || (b == 2 && a >= 12'h800) || (b == 1 && a >= 12'hC00);
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [11:0] edges [6];
    edges = '{12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'h000, 12'hFFF};
    repeat (3) @(negedge clk);
    chk_st(8'h00, "R1");
    rst_n = 1;
    @(negedge clk);
    chk_st(8'h00, "R1");

    wreq(12'h000, 0, "R4 latch clear");
    wrsr(8'hFF);                chk_st(8'h00, "R5");
    wren();                     chk_st(8'h02, "R3 set / R2 layout");
    cyc(0,1,0,0,0,0,0,-1,"");   chk_st(8'h00, "R3 clear");
    wren();
    cyc(1,1,0,0,0,0,0,-1,"");   chk_st(8'h00, "R3 clear wins");

    wren(); wreq(12'h123, 1, "R4 latch set");
    csup();                     chk_st(8'h00, "R10 armed clear");
    wren(); csup();             chk_st(8'h02, "R10 unarmed keeps");

    wrsr(8'h7B);                chk_st(8'h0A, "R6 field mask / R2");
    csup();                     chk_st(8'h08, "R10 after status write");

    for (int b = 0; b < 4; b++) begin
      wren(); wrsr(8'(b << 2)); csup(); wren();
      chk_st(8'(b << 2) | 8'h02, "R7 bp setup");
      for (int k = 0; k < 6; k++)
        wreq(edges[k], prot(b, edges[k]) ? 0 : 1, "R7 range edge");
      csup();
    end

    // R8: SRWD/WP combos. (0,1) covered above.
    settle_wp(1);
    wren(); wrsr(8'h80);        chk_st(8'h82, "R8 srwd=1 wp=1 allowed");
    csup();
    settle_wp(0);
    wren(); wrsr(8'h0C);        chk_st(8'h82, "R8 srwd=1 wp=0 locked");
    csup();                     chk_st(8'h80, "R10 locked write still arms");
    settle_wp(1);
    wren(); wrsr(8'h04);        chk_st(8'h06, "R8 unlock with wp=1");
    csup();
    settle_wp(0);
    wren(); wrsr(8'h08);        chk_st(8'h0A, "R8 srwd=0 wp=0 allowed");
    csup();

    // R9: pin falls in same cycle as status write, old level used
    settle_wp(1);
    wren(); wrsr(8'h80); csup(); wren();
    @(negedge clk); wp_n = 0; cmd_wrsr = 1; wrsr_data = 8'h8C;
    @(negedge clk); cmd_wrsr = 0;
    chk_st(8'h8E, "R9 sync delay");
    csup();
    repeat (3) @(negedge clk);
    wren(); wrsr(8'h00);        chk_st(8'h8E, "R9 pin now seen low");
    settle_wp(1);
    wrsr(8'h00);                chk_st(8'h02, "R8 release");
    csup();

    // R11 collisions
    wren();
    cyc(0,0,0,0,1,12'h100,1,1,"R11 grant with cs rise");
    chk_st(8'h00, "R11 latch cleared after");
    wren();
    cyc(0,0,1,8'h0C,1,12'hFFF,0,1,"R11 grant uses old bp");
    chk_st(8'h0E, "R11 bp updated");
    wreq(12'h000, 0, "R11 new bp applies");
    csup();

    done = 1;
    #1;
    report();
  end
endmodule